// File: doc/BRIEF.md
# Serial-to-Parallel Printer Bridge

This block takes characters arriving on an asynchronous serial line and hands each one to a parallel printer port, with no processor involved. The serial receiver is fixed to eight data bits, one stop bit and no parity. It is paced by a sampling tick that runs at sixteen times the bit rate. For example, a 19.2 kHz tick serves a 1200 bit/s line. A received character waits in a single holding register until the printer can take it.

On the printer side the block watches an active-low busy input. While busy is asserted it holds the character back. Once the printer is free, the block drives the byte onto the data lines, then pulses an active-low strobe. The printer takes the byte on that pulse. Each accepted character also raises a one-clock receive pulse. Two sticky flags record characters that were lost, either to a bad stop bit or to a full holding register.

Top module: `serprint_bridge`

## Requirements
- R1: After reset, prnStrobeN is 1, prnData is 0, and rxIrq, overrunFlag and frameErrFlag are all 0.
- R2: A low serIn seen on a sampleTick while idle counts as sample 0 of a start bit. The start bit is checked at sample 8. If serIn is high there, the event is ignored: no flag is set, no pulse is raised, and the receiver looks for a new start bit.
- R3: Only clocks with sampleTick high advance the receiver. Data bit k (k = 0 is the least significant bit) is taken at sample 8 + 16*(k+1). The printed byte equals the transmitted byte.
- R4: The stop bit is taken at sample 152. If it is high and the holding register is empty, the byte is stored and rxIrq is high for exactly one clock, two clocks after the stop sample edge.
- R5: If the stop bit is sampled low, frameErrFlag is set and stays set until reset. The character is dropped: no rxIrq pulse and no strobe.
- R6: If a valid character completes while the holding register is full, overrunFlag is set and stays set until reset. The new character is discarded and rxIrq stays low.
- R7: A transfer starts only when the register is full and prnBusyN is sampled high while the port is idle. While prnBusyN is low, no strobe starts.
- R8: prnData takes the new byte one clock before prnStrobeN falls. prnData does not change while prnStrobeN is low.
- R9: prnStrobeN stays low for exactly STB_CLKS clocks per character.
- R10: prnData stays unchanged for at least one clock after prnStrobeN rises. The holding register becomes free two clocks after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Oversampling enable, 16 per bit period |
| serIn | input | 1 | Serial receive line, idles high, synchronous to clk |
| prnBusyN | input | 1 | Printer busy, active low |
| prnData | output | DATA_W | Printer data lines |
| prnStrobeN | output | 1 | Printer data strobe, active low |
| rxIrq | output | 1 | One-clock pulse per accepted character |
| overrunFlag | output | 1 | Sticky: character lost to a full holding register |
| frameErrFlag | output | 1 | Sticky: character lost to a low stop bit |

## Verification
The hardest state to reach from the ports is an overrun. A second whole character must finish while the first is still held. In normal running the handshake drains the register within a few clocks, long before the next frame ends. To get there, the stimulus holds prnBusyN low across two complete back-to-back frames. It then checks that the flag is set, that only one receive pulse appeared, and that only the first byte reaches the printer once busy is released. A second hard case is a start glitch of a few samples. It is followed at once by a valid frame, to show that the receiver returned to idle rather than locking up.

// File: rtl/sprb_pkg.sv
package sprb_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_SETUP,
    HS_PULSE,
    HS_HOLD
  } hsState_t;

  // strobes from the handshake control to the datapath
  typedef struct packed {
    logic loadOut;    // copy holding register onto the printer lines
    logic clearHold;  // holding register has been consumed
  } ctlStrobe_t;

endpackage

// File: rtl/sprb_rx.sv
module sprb_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              serIn,
  output logic              frameDone,
  output logic              stopOk,
  output logic [DATA_W-1:0] rxByte
);
  import sprb_pkg::*;

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF  = OSR / 2;

  rxState_t           rxState;
  logic [CNT_W-1:0]   tickCnt;
  logic [IDX_W-1:0]   bitIdx;
  logic [DATA_W-1:0]  shReg;

  assign rxByte = shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      shReg     <= '0;
      frameDone <= 1'b0;
      stopOk    <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (sampleTick) begin
        case (rxState)
          RX_IDLE: begin
            if (!serIn) begin
              rxState <= RX_START;
              tickCnt <= '0;
            end
          end
          RX_START: begin
            if (tickCnt == CNT_W'(HALF - 1)) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              rxState <= serIn ? RX_IDLE : RX_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tickCnt == CNT_W'(OSR - 1)) begin
              tickCnt <= '0;
              shReg   <= {serIn, shReg[DATA_W-1:1]};
              if (bitIdx == IDX_W'(DATA_W - 1)) begin
                rxState <= RX_STOP;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: begin
            if (tickCnt == CNT_W'(OSR - 1)) begin
              tickCnt   <= '0;
              rxState   <= RX_IDLE;
              frameDone <= 1'b1;
              stopOk    <= serIn;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sprb_ctrl.sv
module sprb_ctrl #(
  parameter int STB_CLKS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  holdFull,
  input  logic                  prnBusyN,
  output sprb_pkg::ctlStrobe_t  ctl,
  output logic                  prnStrobeN
);
  import sprb_pkg::*;

  localparam int PC_W = $clog2(STB_CLKS + 1);

  hsState_t         hsState;
  logic [PC_W-1:0]  pulseCnt;
  logic             goXfer;

  assign goXfer        = (hsState == HS_IDLE) && holdFull && prnBusyN;
  assign ctl.loadOut   = goXfer;
  assign ctl.clearHold = (hsState == HS_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsState    <= HS_IDLE;
      pulseCnt   <= '0;
      prnStrobeN <= 1'b1;
    end else begin
      case (hsState)
        HS_IDLE: begin
          if (goXfer) hsState <= HS_SETUP;
        end
        HS_SETUP: begin
          hsState    <= HS_PULSE;
          prnStrobeN <= 1'b0;
          pulseCnt   <= '0;
        end
        HS_PULSE: begin
          if (pulseCnt == PC_W'(STB_CLKS - 1)) begin
            prnStrobeN <= 1'b1;
            hsState    <= HS_HOLD;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end
        default: hsState <= HS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sprb_dpath.sv
module sprb_dpath #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameDone,
  input  logic                 stopOk,
  input  logic [DATA_W-1:0]    rxByte,
  input  sprb_pkg::ctlStrobe_t ctl,
  output logic                 holdFull,
  output logic [DATA_W-1:0]    prnData,
  output logic                 rxIrq,
  output logic                 overrunFlag,
  output logic                 frameErrFlag
);

  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg      <= '0;
      holdFull     <= 1'b0;
      prnData      <= '0;
      rxIrq        <= 1'b0;
      overrunFlag  <= 1'b0;
      frameErrFlag <= 1'b0;
    end else begin
      rxIrq <= 1'b0;
      if (ctl.clearHold) holdFull <= 1'b0;
      if (frameDone) begin
        if (!stopOk) begin
          frameErrFlag <= 1'b1;
        end else if (holdFull) begin
          overrunFlag <= 1'b1;
        end else begin
          holdReg  <= rxByte;
          holdFull <= 1'b1;
          rxIrq    <= 1'b1;
        end
      end
      if (ctl.loadOut) prnData <= holdReg;
    end
  end

endmodule

// File: rtl/serprint_bridge.sv
module serprint_bridge #(
  parameter int DATA_W   = 8,
  parameter int OSR      = 16,
  parameter int STB_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              serIn,
  input  logic              prnBusyN,
  output logic [DATA_W-1:0] prnData,
  output logic              prnStrobeN,
  output logic              rxIrq,
  output logic              overrunFlag,
  output logic              frameErrFlag
);
  import sprb_pkg::*;

  logic              frameDone;
  logic              stopOk;
  logic [DATA_W-1:0] rxByte;
  logic              holdFull;
  ctlStrobe_t        ctl;

  sprb_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .serIn      (serIn),
    .frameDone  (frameDone),
    .stopOk     (stopOk),
    .rxByte     (rxByte)
  );

  sprb_ctrl #(.STB_CLKS(STB_CLKS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .holdFull   (holdFull),
    .prnBusyN   (prnBusyN),
    .ctl        (ctl),
    .prnStrobeN (prnStrobeN)
  );

  sprb_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .frameDone    (frameDone),
    .stopOk       (stopOk),
    .rxByte       (rxByte),
    .ctl          (ctl),
    .holdFull     (holdFull),
    .prnData      (prnData),
    .rxIrq        (rxIrq),
    .overrunFlag  (overrunFlag),
    .frameErrFlag (frameErrFlag)
  );

endmodule

// File: rtl/serprint_bridge_chk.sv
module serprint_bridge_chk #(
  parameter int DATA_W   = 8,
  parameter int STB_CLKS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              prnBusyN,
  input logic [DATA_W-1:0] prnData,
  input logic              prnStrobeN,
  input logic              rxIrq,
  input logic              overrunFlag,
  input logic              frameErrFlag
);

  logic [15:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) lowCnt <= '0;
    else       lowCnt <= prnStrobeN ? 16'd0 : lowCnt + 16'd1;
  end

  AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq); // R4

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    frameErrFlag |=> frameErrFlag); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |=> overrunFlag); // R6

  AST_NO_STROBE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(prnStrobeN) |-> $past(prnBusyN, 2)); // R7

  AST_DATA_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!prnStrobeN && !$fell(prnStrobeN)) |-> $stable(prnData)); // R8

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prnStrobeN) |-> (lowCnt == 16'(STB_CLKS))); // R9

  AST_DATA_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prnStrobeN) |=> $stable(prnData)); // R10

endmodule

bind serprint_bridge serprint_bridge_chk #(.DATA_W(DATA_W), .STB_CLKS(STB_CLKS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .prnBusyN     (prnBusyN),
  .prnData      (prnData),
  .prnStrobeN   (prnStrobeN),
  .rxIrq        (rxIrq),
  .overrunFlag  (overrunFlag),
  .frameErrFlag (frameErrFlag)
);

// File: tb/serprint_bridge_tb.sv
`timescale 1ns/1ps
module serprint_bridge_tb;

  localparam int DATA_W   = 8;
  localparam int OSR      = 16;
  localparam int STB_CLKS = 4;
  localparam int TICKDIV  = 4;
  localparam int HALF     = OSR / 2;
  localparam int STOPIDX  = HALF + OSR * (DATA_W + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleTick = 1'b0;
  logic              serIn = 1'b1;
  logic              prnBusyN = 1'b1;
  logic [DATA_W-1:0] prnData;
  logic              prnStrobeN;
  logic              rxIrq;
  logic              overrunFlag;
  logic              frameErrFlag;

  always #10 clk = ~clk;

  serprint_bridge #(.DATA_W(DATA_W), .OSR(OSR), .STB_CLKS(STB_CLKS)) u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .serIn(serIn),
    .prnBusyN(prnBusyN), .prnData(prnData), .prnStrobeN(prnStrobeN),
    .rxIrq(rxIrq), .overrunFlag(overrunFlag), .frameErrFlag(frameErrFlag)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // tick generator
  int divCnt = 0;
  always @(negedge clk) begin
    divCnt = (divCnt == TICKDIV - 1) ? 0 : divCnt + 1;
    sampleTick <= (divCnt == 0);
  end

  // behavioural reference model
  bit        mActive, mPend, mPendOk, mFull, mIrq, mOv, mFe, mStbN;
  int        mS, mHs, mC;
  logic [7:0] mBits, mPendByte, mHold, mData;

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mPend = 0; mPendOk = 0; mFull = 0; mIrq = 0; mOv = 0; mFe = 0;
      mStbN = 1; mS = 0; mHs = 0; mC = 0; mBits = 0; mPendByte = 0; mHold = 0; mData = 0;
    end else begin
      bit oldFull;
      logic [7:0] oldHold;
      int oldHs;
      oldFull = mFull; oldHold = mHold; oldHs = mHs;
      // holding register and flags
      mIrq = 0;
      if (oldHs == 3) mFull = 0;
      if (mPend) begin
        if (!mPendOk) mFe = 1;
        else if (oldFull) mOv = 1;
        else begin mFull = 1; mHold = mPendByte; mIrq = 1; end
      end
      mPend = 0;
      // printer handshake
      case (oldHs)
        0: if (oldFull && prnBusyN) begin mData = oldHold; mHs = 1; end
        1: begin mHs = 2; mStbN = 0; mC = 0; end
        2: if (mC == STB_CLKS - 1) begin mStbN = 1; mHs = 3; end else mC++;
        default: mHs = 0;
      endcase
      // receiver
      if (sampleTick) begin
        if (!mActive) begin
          if (!serIn) begin mActive = 1; mS = 0; end
        end else begin
          mS++;
          if (mS == HALF) begin
            if (serIn) mActive = 0;
          end else if (mS == STOPIDX) begin
            mActive = 0; mPend = 1; mPendOk = serIn; mPendByte = mBits;
          end else if ((mS - HALF) % OSR == 0) begin
            mBits[(mS - HALF) / OSR - 1] = serIn;
          end
        end
      end
    end
  end

  // per-clock comparison and event monitors
  logic [7:0] printedQ[$];
  logic [7:0] dataAtFall;
  bit  prevStb = 1;
  bit  busyWin = 0;
  int  stbInBusy = 0;
  int  irqCnt = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(prnStrobeN === mStbN, "R9", "strobe", prnStrobeN, mStbN);
      chk(prnData === mData, "R8", "data", prnData, mData);
      chk(rxIrq === mIrq, "R4", "irq", rxIrq, mIrq);
      chk(frameErrFlag === mFe, "R5", "frameErr", frameErrFlag, mFe);
      chk(overrunFlag === mOv, "R6", "overrun", overrunFlag, mOv);
      if (rxIrq) irqCnt++;
      if (prevStb && !prnStrobeN) begin
        printedQ.push_back(prnData);
        dataAtFall = prnData;
        if (busyWin) stbInBusy++;
      end
      if (!prevStb && prnStrobeN)
        chk(prnData === dataAtFall, "R10", "data after rise", prnData, dataAtFall);
      prevStb = prnStrobeN;
    end
  end

  task automatic waitTicks(input int n);
    int cnt = 0;
    while (cnt < n) begin
      @(posedge clk);
      if (sampleTick) cnt++;
    end
    @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    serIn = b;
    waitTicks(OSR);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit goodStop);
    sendBit(1'b0);
    for (int i = 0; i < DATA_W; i++) sendBit(v[i]);
    sendBit(goodStop);
    serIn = 1'b1;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] expQ[$];
    int irqBefore;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(prnStrobeN === 1'b1, "R1", "strobe at reset", prnStrobeN, 1);
    chk(prnData === 8'h00, "R1", "data at reset", prnData, 0);
    chk({rxIrq, overrunFlag, frameErrFlag} === 3'b000, "R1", "flags at reset",
        {rxIrq, overrunFlag, frameErrFlag}, 0);

    waitTicks(20);
    // R3 back-to-back frames
    sendByte(8'hA5, 1); expQ.push_back(8'hA5);
    sendByte(8'h3C, 1); expQ.push_back(8'h3C);
    waitTicks(20);
    chk(irqCnt == 2, "R4", "irq count", irqCnt, 2);

    // R2 start glitch
    irqBefore = irqCnt;
    serIn = 1'b0; waitTicks(3); serIn = 1'b1;
    waitTicks(40);
    chk(irqCnt == irqBefore, "R2", "irq after glitch", irqCnt, irqBefore);
    chk(frameErrFlag === 1'b0, "R2", "frameErr after glitch", frameErrFlag, 0);
    sendByte(8'h01, 1); expQ.push_back(8'h01);
    waitTicks(20);

    // R7 busy holds the transfer back
    prnBusyN = 1'b0; busyWin = 1;
    sendByte(8'h5A, 1); expQ.push_back(8'h5A);
    waitTicks(30);
    chk(stbInBusy == 0, "R7", "strobes while busy", stbInBusy, 0);
    busyWin = 0; prnBusyN = 1'b1;
    waitTicks(10);

    // R6 overrun: two frames while busy
    irqBefore = irqCnt;
    prnBusyN = 1'b0; busyWin = 1;
    sendByte(8'hC3, 1); expQ.push_back(8'hC3);
    sendByte(8'h99, 1);
    waitTicks(10);
    chk(overrunFlag === 1'b1, "R6", "overrun set", overrunFlag, 1);
    chk(irqCnt == irqBefore + 1, "R6", "irq count on overrun", irqCnt, irqBefore + 1);
    chk(stbInBusy == 0, "R7", "strobes while busy", stbInBusy, 0);
    busyWin = 0; prnBusyN = 1'b1;
    waitTicks(10);

    // R5 framing error
    irqBefore = irqCnt;
    sendByte(8'h77, 0);
    waitTicks(30);
    chk(frameErrFlag === 1'b1, "R5", "frameErr set", frameErrFlag, 1);
    chk(irqCnt == irqBefore, "R5", "irq on bad stop", irqCnt, irqBefore);
    sendByte(8'h80, 1); expQ.push_back(8'h80);
    waitTicks(30);

    // R3 printed sequence
    chk(printedQ.size() == expQ.size(), "R3", "printed count", printedQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < printedQ.size(); i++)
      chk(printedQ[i] === expQ[i], "R3", "printed byte", printedQ[i], expQ[i]);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule